// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 30-bit physical address by walking two page tables held in memory. The virtual address splits into a 12-bit outer index in bits 31:20, an 8-bit inner index in bits 19:12 and a 12-bit page offset in bits 11:0, for 4 KB pages. The first memory read fetches an outer entry from a table whose base comes from a root register input. That entry holds the address of an inner table. The second read fetches the inner entry. The inner entry supplies the 18-bit physical page number, and the walker places it in front of the offset.

A caller issues one request through a valid/ready pair and receives a single-cycle response carrying the physical address or a fault. The fault flag names the table level that stopped the walk. Memory is reached through a read port: the address is held until memory accepts it, and the data comes back later with its own valid strobe. While a walk is in progress, new requests are held off.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, while `resp_valid` and `mem_rd_valid` are 0.
- R2: A request is taken only when `req_ready` is 1. `req_ready` stays 0 from the cycle after a request is taken up to and including the response cycle, and the response belongs to the request that was taken.
- R3: The first read goes to `root_base + 4*va[31:20]`, wrapping modulo 2^30. `root_base` is sampled when the request is taken, so changing it during the walk has no effect.
- R4: While `mem_rd_valid` is 1 and `mem_rd_ready` is 0, the read request stays asserted and `mem_rd_addr` does not change.
- R5: An outer entry with bit 31 equal to 0 ends the walk after one read. The response then has `resp_fault`=1, `resp_fault_lvl`=0 and `resp_paddr`=0.
- R6: When the outer entry is valid, the second read goes to `entry[29:0] + 4*va[19:12]`, wrapping modulo 2^30.
- R7: An inner entry with bit 31 equal to 0 ends the walk with `resp_fault`=1, `resp_fault_lvl`=1 and `resp_paddr`=0.
- R8: When both entries are valid, exactly two reads are made and the response is `resp_paddr = {inner[17:0], va[11:0]}` with `resp_fault`=0.
- R9: `resp_valid` is high for exactly one cycle, and `req_ready` is 1 in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| root_base | input | 30 | Byte address of the outer table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, can take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| resp_valid | output | 1 | One-cycle result strobe |
| resp_paddr | output | 30 | Physical address (0 on fault) |
| resp_fault | output | 1 | Walk hit an invalid entry |
| resp_fault_lvl | output | 1 | 0 = outer entry, 1 = inner entry |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 30 | Byte address of the entry read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Entry word, bit 31 = valid |

## Verification
The bench builds the block with its default field widths: 12/8/12 index and offset bits, a 30-bit physical address and 32-bit entries. A memory model answers with random accept stalls and random response delays, so the address-hold case is exercised. Random root bases and all-ones indices reach the 2^30 wrap of both address sums. Entry-valid modes force faults at each level and also mix random faults with complete walks.

// File: rtl/ptw_pkg.sv
// Package: shared state encoding for the page table walker.
// Assumes: one walk in flight at a time.
package ptw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_RD_OUTER   = 3'd1,
        ST_WT_OUTER   = 3'd2,
        ST_RD_INNER   = 3'd3,
        ST_WT_INNER   = 3'd4,
        ST_DONE       = 3'd5
    } ptw_state_e;
endpackage

// File: rtl/ptw_addr_gen.sv
// Module: forms an entry byte address as table base + 4*index, modulo 2^PA_W.
// Assumes: entries are 4 bytes and PA_W > IDX_W + 2.
module ptw_addr_gen #(
    parameter int PA_W  = 30,
    parameter int IDX_W = 12
) (
    input  logic [PA_W-1:0]  base,
    input  logic [IDX_W-1:0] idx,
    output logic [PA_W-1:0]  addr
);
    localparam int PAD_W = PA_W - IDX_W - 2;

    // purpose: scale the index to a byte offset and add it to the base
    always_comb begin
        addr = base + {{PAD_W{1'b0}}, idx, 2'b00};
    end
endmodule

// File: rtl/ptw_entry_check.sv
// Module: splits a table entry word into its valid flag and payload field.
// Assumes: the valid flag is the top bit; the payload sits in the low FIELD_W bits.
module ptw_entry_check #(
    parameter int DATA_W  = 32,
    parameter int FIELD_W = 30
) (
    input  logic [DATA_W-1:0]  word,
    output logic               ok,
    output logic [FIELD_W-1:0] field
);
    logic unused_rsvd;

    // purpose: pick apart the valid flag and the payload field
    always_comb begin
        ok          = word[DATA_W-1];
        field       = word[FIELD_W-1:0];
        unused_rsvd = ^word[DATA_W-2:FIELD_W];
    end
endmodule

// File: rtl/ptw_ctrl.sv
// Module: sequencer for the two dependent table reads and the response.
// Assumes: memory answers each accepted read with exactly one mem_rsp_valid pulse,
// and never sends a response while no read is outstanding.
module ptw_ctrl
    import ptw_pkg::*;
#(
    parameter int OUT_IDX_W = 12,
    parameter int IN_IDX_W  = 8,
    parameter int OFF_W     = 12,
    parameter int PA_W      = 30
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               req_valid,
    output logic                               req_ready,
    input  logic [OUT_IDX_W+IN_IDX_W+OFF_W-1:0] req_vaddr,
    input  logic [PA_W-1:0]                    root_base,
    output logic [PA_W-1:0]                    base_q,
    output logic [OUT_IDX_W-1:0]               outer_idx,
    output logic [IN_IDX_W-1:0]                inner_idx,
    output logic [PA_W-1:0]                    tbl_q,
    input  logic [PA_W-1:0]                    outer_addr,
    input  logic [PA_W-1:0]                    inner_addr,
    output logic                               mem_rd_valid,
    input  logic                               mem_rd_ready,
    output logic [PA_W-1:0]                    mem_rd_addr,
    input  logic                               mem_rsp_valid,
    input  logic                               ent_ok,
    input  logic [PA_W-1:0]                    ent_field,
    output logic                               resp_valid,
    output logic [PA_W-1:0]                    resp_paddr,
    output logic                               resp_fault,
    output logic                               resp_fault_lvl
);
    localparam int VA_W  = OUT_IDX_W + IN_IDX_W + OFF_W;
    localparam int PPN_W = PA_W - OFF_W;

    ptw_state_e       state, state_nx;
    logic [VA_W-1:0]  vaddr_q;
    logic [PPN_W-1:0] ppn_q;
    logic             fault_q;
    logic             lvl_q;

    // purpose: pick the next walk state from handshakes and entry validity
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (req_valid)     state_nx = ST_RD_OUTER;
            ST_RD_OUTER: if (mem_rd_ready)  state_nx = ST_WT_OUTER;
            ST_WT_OUTER: if (mem_rsp_valid) state_nx = ent_ok ? ST_RD_INNER : ST_DONE;
            ST_RD_INNER: if (mem_rd_ready)  state_nx = ST_WT_INNER;
            ST_WT_INNER: if (mem_rsp_valid) state_nx = ST_DONE;
            ST_DONE:                        state_nx = ST_IDLE;
            default:                        state_nx = ST_IDLE;
        endcase
    end

    // purpose: state register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // purpose: capture request, table address, page number and fault outcome
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vaddr_q <= '0;
            base_q  <= '0;
            tbl_q   <= '0;
            ppn_q   <= '0;
            fault_q <= 1'b0;
            lvl_q   <= 1'b0;
        end else begin
            if (state == ST_IDLE && req_valid) begin
                vaddr_q <= req_vaddr;
                base_q  <= root_base;
                fault_q <= 1'b0;
                lvl_q   <= 1'b0;
            end
            if (state == ST_WT_OUTER && mem_rsp_valid) begin
                if (ent_ok) begin
                    tbl_q <= ent_field;
                end else begin
                    fault_q <= 1'b1;
                    lvl_q   <= 1'b0;
                end
            end
            if (state == ST_WT_INNER && mem_rsp_valid) begin
                if (ent_ok) begin
                    ppn_q <= ent_field[PPN_W-1:0];
                end else begin
                    fault_q <= 1'b1;
                    lvl_q   <= 1'b1;
                end
            end
        end
    end

    // purpose: index fields of the captured address for the address generators
    always_comb begin
        outer_idx = vaddr_q[VA_W-1 -: OUT_IDX_W];
        inner_idx = vaddr_q[OFF_W +: IN_IDX_W];
    end

    // purpose: drive the memory read port from the current read state
    always_comb begin
        mem_rd_valid = (state == ST_RD_OUTER) || (state == ST_RD_INNER);
        mem_rd_addr  = (state == ST_RD_INNER) ? inner_addr : outer_addr;
    end

    // purpose: handshake and response outputs
    always_comb begin
        req_ready      = (state == ST_IDLE);
        resp_valid     = (state == ST_DONE);
        resp_fault     = fault_q;
        resp_fault_lvl = lvl_q;
        resp_paddr     = fault_q ? '0 : {ppn_q, vaddr_q[OFF_W-1:0]};
    end

    // R2: a taken request makes the walker busy in the next cycle
    a_r2_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R2: never idle while reading memory or responding
    a_r2_ready_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_rd_valid && !resp_valid));

    // R4: a stalled read keeps its request and address
    a_r4_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    // R9: response lasts one cycle, then the walker is idle
    a_r9_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> (!resp_valid && req_ready));

    // R5 / R7: a faulting response carries a zero address
    a_r5_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault) |-> (resp_paddr == '0));
endmodule

// File: rtl/pt_walker.sv
// Module: two-level page table walker top; wires the sequencer, the two
// entry address generators and the entry decoder together.
// Assumes: outer table base is a byte address; entries are 32-bit words with
// the valid flag in the top bit.
module pt_walker #(
    parameter int OUT_IDX_W = 12,
    parameter int IN_IDX_W  = 8,
    parameter int OFF_W     = 12,
    parameter int PA_W      = 30,
    parameter int DATA_W    = 32
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [PA_W-1:0]                     root_base,
    input  logic                                req_valid,
    output logic                                req_ready,
    input  logic [OUT_IDX_W+IN_IDX_W+OFF_W-1:0] req_vaddr,
    output logic                                resp_valid,
    output logic [PA_W-1:0]                     resp_paddr,
    output logic                                resp_fault,
    output logic                                resp_fault_lvl,
    output logic                                mem_rd_valid,
    input  logic                                mem_rd_ready,
    output logic [PA_W-1:0]                     mem_rd_addr,
    input  logic                                mem_rsp_valid,
    input  logic [DATA_W-1:0]                   mem_rsp_data
);
    logic [PA_W-1:0]      base_q, tbl_q, outer_addr, inner_addr, ent_field;
    logic [OUT_IDX_W-1:0] outer_idx;
    logic [IN_IDX_W-1:0]  inner_idx;
    logic                 ent_ok;

    ptw_addr_gen #(.PA_W(PA_W), .IDX_W(OUT_IDX_W)) u_outer_ag (
        .base (base_q),
        .idx  (outer_idx),
        .addr (outer_addr)
    );

    ptw_addr_gen #(.PA_W(PA_W), .IDX_W(IN_IDX_W)) u_inner_ag (
        .base (tbl_q),
        .idx  (inner_idx),
        .addr (inner_addr)
    );

    ptw_entry_check #(.DATA_W(DATA_W), .FIELD_W(PA_W)) u_chk (
        .word  (mem_rsp_data),
        .ok    (ent_ok),
        .field (ent_field)
    );

    ptw_ctrl #(
        .OUT_IDX_W (OUT_IDX_W),
        .IN_IDX_W  (IN_IDX_W),
        .OFF_W     (OFF_W),
        .PA_W      (PA_W)
    ) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_vaddr      (req_vaddr),
        .root_base      (root_base),
        .base_q         (base_q),
        .outer_idx      (outer_idx),
        .inner_idx      (inner_idx),
        .tbl_q          (tbl_q),
        .outer_addr     (outer_addr),
        .inner_addr     (inner_addr),
        .mem_rd_valid   (mem_rd_valid),
        .mem_rd_ready   (mem_rd_ready),
        .mem_rd_addr    (mem_rd_addr),
        .mem_rsp_valid  (mem_rsp_valid),
        .ent_ok         (ent_ok),
        .ent_field      (ent_field),
        .resp_valid     (resp_valid),
        .resp_paddr     (resp_paddr),
        .resp_fault     (resp_fault),
        .resp_fault_lvl (resp_fault_lvl)
    );
endmodule

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [29:0] root_base = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        resp_valid;
    logic [29:0] resp_paddr;
    logic        resp_fault, resp_fault_lvl;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b0;
    logic [29:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int mode = 0;              // 0 all valid, 1 random, 2 outer invalid, 3 inner invalid
    logic [29:0] cur_outer = '0;
    int rd_cnt = 0;
    logic [29:0] rd_log [4];
    logic [31:0] seed_k = 32'h1234_5678;

    pt_walker u_pt_walker (
        .clk(clk), .rst_n(rst_n), .root_base(root_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .resp_valid(resp_valid), .resp_paddr(resp_paddr), .resp_fault(resp_fault),
        .resp_fault_lvl(resp_fault_lvl), .mem_rd_valid(mem_rd_valid),
        .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    always #2.5 clk = ~clk;

    function automatic logic [31:0] hsh(input logic [29:0] a);
        logic [31:0] x;
        x = {2'b00, a} ^ seed_k;
        x = x * 32'h9E37_79B1;
        x = x ^ (x >> 15);
        x = x * 32'h85EB_CA6B;
        x = x ^ (x >> 13);
        return x;
    endfunction

    // memory content model: bit 31 valid per mode, rest from a hash
    function automatic logic [31:0] mem_fn(input logic [29:0] a);
        logic [31:0] h;
        logic v;
        h = hsh(a);
        case (mode)
            0: v = 1'b1;
            1: v = h[7] | h[3];
            2: v = 1'b0;
            default: v = (a == cur_outer);
        endcase
        return {v, h[30:0]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory responder: random accept stalls and response delay
    initial begin
        bit pend = 0;
        logic [29:0] paddr_q = '0;
        int dly = 0;
        bit prev_stall = 0;
        logic [29:0] prev_addr = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (pend) begin
                if (dly == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = mem_fn(paddr_q);
                    pend = 0;
                end else dly--;
            end
            mem_rd_ready = pend ? 1'b0 : ($urandom % 3 != 0);
            #1;
            if (prev_stall) // R4
                check(mem_rd_valid && mem_rd_addr == prev_addr, "R4 stalled read held",
                      {mem_rd_valid, 1'b0, mem_rd_addr}, {2'b10, prev_addr});
            prev_stall = mem_rd_valid && !mem_rd_ready;
            prev_addr  = mem_rd_addr;
            if (mem_rd_valid && mem_rd_ready && rst_n) begin
                pend = 1;
                paddr_q = mem_rd_addr;
                dly = $urandom % 3;
                if (rd_cnt < 4) rd_log[rd_cnt] = mem_rd_addr;
                rd_cnt++;
            end
        end
    end

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                checks++; errors++;
                $display("FAIL watchdog actual=%0d expected=<150000", cycles);
                finish_run();
            end
        end
    end

    task automatic walk(input logic [31:0] va, input logic [29:0] base, input int md, input bit hold);
        logic [29:0] e_outer, e_inner, e_pa;
        logic [31:0] ent0, ent1;
        int e_reads;
        bit e_fault, e_lvl, busy_ok;
        int n;
        mode = md;
        e_outer = base + {8'd0, va[31:20], 2'b00};
        cur_outer = e_outer;
        ent0 = mem_fn(e_outer);
        e_inner = '0; e_pa = '0; e_lvl = 0;
        if (!ent0[31]) begin
            e_reads = 1; e_fault = 1; e_lvl = 0;
        end else begin
            e_inner = ent0[29:0] + {20'd0, va[19:12], 2'b00};
            ent1 = mem_fn(e_inner);
            e_reads = 2;
            if (!ent1[31]) begin e_fault = 1; e_lvl = 1; end
            else begin e_fault = 0; e_pa = {ent1[17:0], va[11:0]}; end
        end
        @(negedge clk);
        rd_cnt = 0;
        root_base = base;
        req_valid = 1'b1;
        req_vaddr = va;
        #2;
        check(req_ready == 1'b1, "R2 idle ready", {31'd0, req_ready}, 32'd1);
        @(negedge clk);
        req_valid = hold;
        req_vaddr = ~va;
        root_base = $urandom; // R3: must not affect this walk
        busy_ok = 1; n = 0;
        #2;
        while (!resp_valid && n < 60) begin
            if (req_ready) busy_ok = 0;
            @(negedge clk); #2; n++;
        end
        req_valid = 1'b0;
        check(busy_ok && !req_ready, "R2 held off while busy", {31'd0, busy_ok}, 32'd1);
        check(resp_valid, "R9 response arrives", {31'd0, resp_valid}, 32'd1);
        check(rd_cnt == e_reads, "R8 read count", rd_cnt, e_reads);
        check(rd_log[0] == e_outer, "R3 outer address", {2'b0, rd_log[0]}, {2'b0, e_outer});
        if (e_reads == 2)
            check(rd_log[1] == e_inner, "R6 inner address", {2'b0, rd_log[1]}, {2'b0, e_inner});
        if (e_fault && !e_lvl)
            check(resp_fault && !resp_fault_lvl && resp_paddr == 0, "R5 outer fault",
                  {resp_fault, resp_fault_lvl, resp_paddr}, {2'b10, 30'd0});
        else if (e_fault)
            check(resp_fault && resp_fault_lvl && resp_paddr == 0, "R7 inner fault",
                  {resp_fault, resp_fault_lvl, resp_paddr}, {2'b11, 30'd0});
        else
            check(!resp_fault && resp_paddr == e_pa, "R8 translated address",
                  {resp_fault, resp_fault_lvl, resp_paddr}, {2'b00, e_pa});
        @(negedge clk); #2;
        check(!resp_valid && req_ready, "R9 single response cycle",
              {30'd0, resp_valid, req_ready}, 32'd1);
    endtask

    initial begin
        rd_log[0] = '0; rd_log[1] = '0; rd_log[2] = '0; rd_log[3] = '0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        check(req_ready && !resp_valid && !mem_rd_valid, "R1 reset state",
              {29'd0, req_ready, resp_valid, mem_rd_valid}, 32'd4);
        // directed corners
        walk(32'h0000_0000, 30'h0,          0, 0);
        walk(32'hFFFF_FFFF, 30'h3FFF_FFFC, 0, 1);   // R3 wrap with all-ones indices
        walk(32'hABCD_E123, 30'h0010_0000, 2, 0);   // R5
        walk(32'h1234_5FFF, 30'h0020_0000, 3, 1);   // R7
        walk(32'hFFF0_0ABC, 30'h3FFF_F000, 3, 0);
        // random mix
        for (int i = 0; i < 400; i++)
            walk($urandom, $urandom, $urandom % 4, $urandom % 2);
        finish_run();
    end
endmodule